// File: doc/BRIEF.md
# Column Driver Lockstep Watchdog

Several column-driver tiles share one display. One tile, the master, generates the frame and line strobes, and every other tile, a slave, follows them. Each slave also builds its own copy of the two row-driver level-select signals. If noise makes a slave drop or gain a line strobe, its copy no longer matches the master's. This block sits in each tile and finds that loss of lockstep. At every rising edge of the active-low frame pulse, which comes once per half-frame, it compares the master's pair of level-select bits with the locally generated pair.

On a mismatch, a slave pulls a shared open-drain refresh line low for a fixed number of cycles. Every tile on the line, this one included, passes the line through a two-flop synchronizer. While the synchronized line is low, the tile holds its timing counters in reset and asks for the display to be blanked. Blanking continues for a set number of full frames after the line is released, and it also follows a power-on reset. After any reset the first half-frame edge only arms the comparator, so a tile never retriggers on the disturbance it has just caused.

Top module: `lockstep_watchdog`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `rfsh_pull` and `timing_rst` are 0 and `blank_req` is 1.
- R2: When `slave_mode` is 0 the block never asserts `rfsh_pull`, whatever the level-select inputs are.
- R3: A frame edge is a clock cycle in which `frm_n` is sampled 1 and was sampled 0 in the previous cycle. In a slave that is armed and not already pulling, a frame edge where `mst_lvl1`≠`loc_lvl1` or `mst_lvl2`≠`loc_lvl2` asserts `rfsh_pull` from the next cycle. Mismatches outside frame edges have no effect.
- R4: Each refresh pull lasts exactly PULSE_CYCLES (default 4) cycles and is not extended by further mismatches while it is active.
- R5: `rfsh_sense` passes through two flip-flops. `timing_rst` is 1 in exactly those cycles whose synchronized level is low, so it rises two cycles after the line goes low, whichever tile pulled it.
- R6: `blank_req` is 1 while `timing_rst` is 1. After reset, and after `timing_rst` falls, it stays 1 until 2×BLANK_FRAMES (default 8) further frame edges have passed.
- R7: After reset, and after `timing_rst` falls, the first frame edge only arms the comparator. A mismatch at that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| slave_mode | input | 1 | 1 = this tile follows the master and runs the comparison |
| frm_n | input | 1 | Active-low frame pulse; its rising edge marks a half-frame |
| mst_lvl1 | input | 1 | Master's first level-select bit |
| mst_lvl2 | input | 1 | Master's second level-select bit |
| loc_lvl1 | input | 1 | Locally generated first level-select bit |
| loc_lvl2 | input | 1 | Locally generated second level-select bit |
| rfsh_sense | input | 1 | Sensed level of the shared refresh line |
| rfsh_pull | output | 1 | 1 = drive the shared refresh line low; 0 = release it |
| timing_rst | output | 1 | Internal reset for the tile's timing counters |
| blank_req | output | 1 | Request to turn the display off |

## Verification
The bench chases the mismatch that coincides with the first edge after a recovery. A design without the arming mask would pull the line again and loop through refreshes without end. It also fires mismatches between edges and during a pull: a comparator that is not gated by the edge, or a counter that reloads, would show up as stray or stretched pulses. A refresh pulled by another tile must reset and blank this tile with the same two-cycle latency, and master mode must stay silent. Blank release is counted edge by edge, so an off-by-one in the half-frame count is visible.

// File: rtl/lockstep_watchdog.sv
module lockstep_watchdog #(
  parameter int PULSE_CYCLES = 4,
  parameter int BLANK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic frm_n,
  input  logic mst_lvl1,
  input  logic mst_lvl2,
  input  logic loc_lvl1,
  input  logic loc_lvl2,
  input  logic rfsh_sense,
  output logic rfsh_pull,
  output logic timing_rst,
  output logic blank_req
);
  localparam int HALVES = 2 * BLANK_FRAMES;
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int BW = $clog2(HALVES + 1);

  logic          frm_q, armed, s1, s2;
  logic [PW-1:0] drv_cnt;
  logic [BW-1:0] blank_cnt;

  wire frm_rise = frm_n & ~frm_q;
  wire line_low = ~s2;
  wire differ   = (mst_lvl1 ^ loc_lvl1) | (mst_lvl2 ^ loc_lvl2);
  wire fire     = slave_mode & armed & frm_rise & differ & (drv_cnt == '0) & ~line_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= 1'b1;
      s1    <= 1'b1;
      s2    <= 1'b1;
    end else begin
      frm_q <= frm_n;
      s1    <= rfsh_sense;
      s2    <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              drv_cnt <= '0;
    else if (fire)           drv_cnt <= PW'(PULSE_CYCLES);
    else if (drv_cnt != '0)  drv_cnt <= drv_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (line_low)  armed <= 1'b0;
    else if (frm_rise)  armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             blank_cnt <= BW'(HALVES);
    else if (line_low)                      blank_cnt <= BW'(HALVES);
    else if (frm_rise && blank_cnt != '0)   blank_cnt <= blank_cnt - 1'b1;
  end

  assign rfsh_pull  = (drv_cnt != '0);
  assign timing_rst = line_low;
  assign blank_req  = line_low | (blank_cnt != '0);

  a_r2_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && drv_cnt == '0) |=> !rfsh_pull);
  a_r3_pull_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_pull) |-> $past(frm_rise && differ));
  a_r4_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_pull && drv_cnt > 1) |=> rfsh_pull);
  a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timing_rst) |-> $past(!rfsh_sense, 2));
  a_r6_blank_cover: assert property (@(posedge clk) disable iff (!rst_n)
    timing_rst |-> blank_req);
  a_r7_mask_first: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_rise && !armed && drv_cnt == '0) |=> !rfsh_pull);
endmodule

// File: tb/sim_lockstep_watchdog.sv
module sim_lockstep_watchdog;
  logic clk = 0, rst_n = 0, slave_mode = 1, frm_n = 1;
  logic m1 = 0, m2 = 0, l1 = 0, l2 = 0, ext_pull = 0;
  logic pull, trst, blank;
  wire  line = ~(pull | ext_pull);
  int checks = 0, fails = 0, cyc = 0;
  int m_prev, m_armed, m_drv, m_s1, m_s2, m_blank, run_len, pulses;
  bit m_fire;

  always #5 clk = ~clk;

  lockstep_watchdog u0 (.clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .frm_n(frm_n),
    .mst_lvl1(m1), .mst_lvl2(m2), .loc_lvl1(l1), .loc_lvl2(l2),
    .rfsh_sense(line), .rfsh_pull(pull), .timing_rst(trst), .blank_req(blank));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 1; m_armed = 0; m_drv = 0; m_s1 = 1; m_s2 = 1; m_blank = 8;
    end else begin
      bit rise, low;
      rise = frm_n && !m_prev;
      low  = !m_s2;
      m_fire = slave_mode && m_armed && rise && ((m1 != l1) || (m2 != l2)) && m_drv == 0 && !low;
      m_drv = m_fire ? 4 : (m_drv > 0 ? m_drv - 1 : 0);
      if (low) m_armed = 0; else if (rise) m_armed = 1;
      if (low) m_blank = 8; else if (rise && m_blank > 0) m_blank--;
      m_s2 = m_s1; m_s1 = line; m_prev = frm_n;
    end
  end

  always @(negedge clk) begin
    cyc++;
    chk("R3/R4 pull", pull, m_drv > 0);
    chk("R5 timing_rst", trst, m_s2 == 0);
    chk("R6 blank_req", blank, (m_s2 == 0) || (m_blank > 0));
    if (pull) run_len++;
    else if (run_len != 0) begin
      chk("R4 pulse length", run_len == 4, 1'b1);
      pulses++; run_len = 0;
    end
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // one half-frame: frm_n low 2 cycles, then high; values at the edge given, wrong values elsewhere
  task automatic half(input logic a, input logic b, input logic noisy);
    @(negedge clk); frm_n = 0; {m1, m2} = noisy ? 2'b10 : 2'b00; {l1, l2} = 2'b00;
    @(negedge clk);
    @(negedge clk); frm_n = 1; m1 = a; m2 = b; l1 = 0; l2 = 0;
    @(negedge clk); {m1, m2} = noisy ? 2'b01 : 2'b00;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pull in reset", pull, 1'b0);
    chk("R1 timing_rst in reset", trst, 1'b0);
    chk("R1 blank in reset", blank, 1'b1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 blank after reset", blank, 1'b1);
    half(1, 0, 0);                        // arming edge, mismatch masked (R7)
    chk("R7 masked after reset", pull, 1'b0);
    repeat (8) half(0, 0, 1);             // matching edges, noise between (R3), blank expires (R6)
    chk("R6 blank released", blank, 1'b0);
    chk("R3 noise ignored", pulses == 0, 1'b1);
    half(1, 0, 0);                        // mismatch on first bit
    chk("R3 first-bit refresh", pulses == 1, 1'b1);
    half(0, 1, 0);                        // first edge after release: masked (R7)
    chk("R7 masked after refresh", pulses == 1, 1'b1);
    half(0, 1, 0);                        // mismatch on second bit
    chk("R3 second-bit refresh", pulses == 2, 1'b1);
    repeat (9) half(0, 0, 0);
    @(negedge clk); ext_pull = 1;         // another tile pulls (R5)
    repeat (6) @(negedge clk); ext_pull = 0;
    chk("R5 external pull no own drive", pulses == 2, 1'b1);
    repeat (10) half(0, 0, 0);
    chk("R6 blank after external", blank, 1'b0);
    slave_mode = 0;
    repeat (4) half(1, 1, 0);
    chk("R2 master silent", pulses == 2, 1'b1);
    chk("R2 master pull low", pull, 1'b0);
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule